// File: doc/BRIEF.md
# Reversible Gate Cascade Evaluator

This block evaluates a loadable cascade of reversible gates acting on a small set of wires (2 to 4, three by default). Each stored gate is a single inverter, a one-control inverter, a two-control inverter, or an exchange of two wires. Gates are applied in list order, with no fan-out between stages. Software or a sequencer fills the gate list through a write port, sets the number of active gates and pulses `start`.

The block then drives every input code through the cascade, one gate per clock, and stores the image of each code in a result table that can be read combinationally. Next it checks that no image occurs twice. If the mapping is a bijection, it walks the table as a set of cycles and reports whether the permutation is even or odd. A gate whose indices are out of range, or whose control sits on its own target, stops the run with an error flag.

Top module: `rev_cascade_eval`

## Requirements
- R1: A gate entry packs an opcode (0 = single inverter, 1 = one-control inverter, 2 = two-control inverter, 3 = exchange), a target index, a first auxiliary index and a second auxiliary index. Wire w is bit w of a code. The single inverter always flips its target wire.
- R2: The one-control inverter flips its target only when its first auxiliary wire (the control) is 1, and leaves every other wire alone. On three wires, control wire 1 with target wire 0 maps 2→3, 3→2, 6→7 and 7→6, and fixes every other code.
- R3: The two-control inverter flips its target only when both auxiliary wires are 1. A cascade made only of such gates maps 0 and every one-hot code to itself.
- R4: The exchange gate swaps the values of its target wire and its first auxiliary wire.
- R5: Entries 0 to `gate_cnt-1` are applied in ascending order, so exchanging two different gates changes the result. A count of zero yields the identity mapping.
- R6: `busy` rises in the cycle after an accepted `start` and falls in the cycle in which `done` pulses. After `done`, `rd_data` gives the image of `rd_addr`.
- R7: A run with only legal gates ends with `is_perm` = 1.
- R8: `is_odd` equals the parity of (2^N minus the number of cycles in the mapping). A cascade in which no gate touches every wire reports even, and a lone two-control inverter on three wires reports odd.
- R9: A gate is illegal if any index it uses is N or greater, or if one of its controls equals its target. An illegal gate ends the run with `err` = 1, `is_perm` = 0 and `is_odd` = 0.
- R10: A gate-list write while `busy` is high is dropped. A write in the same cycle as an accepted `start` is kept and is used by that run.
- R11: `done` is high for exactly one cycle. `err`, `is_perm`, `is_odd` and the table hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one gate entry |
| wr_addr | input | $clog2(MAX_GATES) | Gate entry index |
| wr_op | input | 2 | Gate opcode |
| wr_tgt | input | 2 | Target wire index |
| wr_aux_a | input | 2 | First control, or exchange partner |
| wr_aux_b | input | 2 | Second control |
| gate_cnt | input | $clog2(MAX_GATES+1) | Number of active gates, sampled at start |
| start | input | 1 | Begin an evaluation (taken while idle) |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Run aborted on an illegal gate |
| is_perm | output | 1 | Mapping is a bijection |
| is_odd | output | 1 | Mapping is an odd permutation |
| rd_addr | input | N_WIRES | Result table read index |
| rd_data | output | N_WIRES | Image of `rd_addr` |

## Verification
A gate-list write and an accepted `start` can occur in the same cycle. The bench raises both together, writing a two-control inverter into entry 0 with a count of one. It expects the result table and odd parity of that gate, not those of the entry the write replaced. The opposite case is also covered: a write issued the cycle after `start`, while `busy` is high. The bench shows that this write was dropped by rerunning without any new writes and finding the earlier mapping unchanged.

// File: rtl/rce_pkg.sv
package rce_pkg;
   localparam int RCE_IDX_W = 2;
   localparam int RCE_MAX_WIRES = 1 << RCE_IDX_W;

   typedef enum logic [1:0] {
      OP_INV  = 2'd0,
      OP_CX   = 2'd1,
      OP_CCX  = 2'd2,
      OP_XCHG = 2'd3
   } rce_op_e;

   typedef struct packed {
      rce_op_e                op;
      logic [RCE_IDX_W-1:0]   tgt;
      logic [RCE_IDX_W-1:0]   aux_a;
      logic [RCE_IDX_W-1:0]   aux_b;
   } rce_gate_t;
endpackage

// File: rtl/rce_gate_store.sv
module rce_gate_store
   import rce_pkg::*;
#(
   parameter int MAX_GATES = 16,
   localparam int ADDR_W = $clog2(MAX_GATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              lock_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  rce_gate_t         wr_gate_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output rce_gate_t         rd_gate_o
);
   rce_gate_t [MAX_GATES-1:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else if (wr_en_i && !lock_i) begin
         mem[wr_addr_i] <= wr_gate_i;
      end
   end

   assign rd_gate_o = mem[rd_addr_i];

   // R10
   list_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(mem));
endmodule

// File: rtl/rce_gate_apply.sv
module rce_gate_apply
   import rce_pkg::*;
#(
   parameter int N_WIRES = 3
) (
   input  logic [N_WIRES-1:0] state_i,
   input  rce_gate_t          gate_i,
   output logic [N_WIRES-1:0] state_o,
   output logic               illegal_o
);
   localparam int PAD_W = RCE_MAX_WIRES;

   logic [PAD_W-1:0] sp;
   logic             fire;
   logic             tgt_bad, a_bad, b_bad;

   assign sp = PAD_W'(state_i);

   function automatic logic idx_bad(input logic [RCE_IDX_W-1:0] x);
      return ({1'b0, x} >= (RCE_IDX_W+1)'(N_WIRES));
   endfunction

   always_comb begin
      tgt_bad = idx_bad(gate_i.tgt);
      a_bad   = idx_bad(gate_i.aux_a);
      b_bad   = idx_bad(gate_i.aux_b);
      unique case (gate_i.op)
         OP_INV:  illegal_o = tgt_bad;
         OP_CX:   illegal_o = tgt_bad || a_bad || (gate_i.aux_a == gate_i.tgt);
         OP_CCX:  illegal_o = tgt_bad || a_bad || b_bad ||
                              (gate_i.aux_a == gate_i.tgt) || (gate_i.aux_b == gate_i.tgt);
         default: illegal_o = tgt_bad || a_bad;
      endcase
      unique case (gate_i.op)
         OP_INV:  fire = 1'b1;
         OP_CX:   fire = sp[gate_i.aux_a];
         OP_CCX:  fire = sp[gate_i.aux_a] & sp[gate_i.aux_b];
         default: fire = 1'b0;
      endcase
   end

   for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
      localparam logic [RCE_IDX_W-1:0] WI = RCE_IDX_W'(w);
      always_comb begin
         if (gate_i.op == OP_XCHG) begin
            if (gate_i.tgt == WI)        state_o[w] = sp[gate_i.aux_a];
            else if (gate_i.aux_a == WI) state_o[w] = sp[gate_i.tgt];
            else                         state_o[w] = sp[w];
         end else begin
            state_o[w] = sp[w] ^ (fire && (gate_i.tgt == WI));
         end
      end
   end

   always_comb begin
      if (!illegal_o && gate_i.op != OP_XCHG) begin
         // R2 R3
         target_only_chk: assert ((PAD_W'(state_o ^ state_i) & ~(PAD_W'(1) << gate_i.tgt)) == '0);
      end
      if (!illegal_o && gate_i.op == OP_XCHG) begin
         // R4
         swap_weight_chk: assert ($countones(state_o) == $countones(state_i));
      end
   end
endmodule

// File: rtl/rce_parity_walk.sv
module rce_parity_walk #(
   parameter int N_WIRES = 3,
   localparam int DEPTH = 1 << N_WIRES,
   localparam int CW = N_WIRES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   output logic [CW-1:0] look_addr_o,
   input  logic [CW-1:0] look_data_i,
   output logic          fin_o,
   output logic          odd_o
);
   localparam logic [CW-1:0] LAST    = CW'(DEPTH - 1);
   localparam logic [CW:0]   DEPTH_V = (CW+1)'(DEPTH);

   typedef enum logic [1:0] {W_IDLE, W_SEEK, W_FOLLOW, W_FIN} wst_e;

   wst_e             st;
   logic [DEPTH-1:0] visited;
   logic [CW-1:0]    head, pos;
   logic [CW:0]      cycles;
   logic [CW:0]      diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= W_IDLE;
         visited <= '0;
         head    <= '0;
         pos     <= '0;
         cycles  <= '0;
      end else begin
         unique case (st)
            W_IDLE: if (go_i) begin
               visited <= '0;
               head    <= '0;
               cycles  <= '0;
               st      <= W_SEEK;
            end
            W_SEEK: begin
               if (visited[head]) begin
                  if (head == LAST) st <= W_FIN;
                  else              head <= head + 1'b1;
               end else begin
                  cycles <= cycles + 1'b1;
                  pos    <= head;
                  st     <= W_FOLLOW;
               end
            end
            W_FOLLOW: begin
               visited[pos] <= 1'b1;
               if (look_data_i == head) begin
                  if (head == LAST) st <= W_FIN;
                  else begin
                     head <= head + 1'b1;
                     st   <= W_SEEK;
                  end
               end else begin
                  pos <= look_data_i;
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   assign look_addr_o = pos;
   assign diff        = DEPTH_V - cycles;
   assign fin_o       = (st == W_FIN);
   assign odd_o       = diff[0];

   // R8
   all_visited_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_FIN) |-> (&visited));

   // R8
   cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycles <= DEPTH_V);
endmodule

// File: rtl/rev_cascade_eval.sv
module rev_cascade_eval
   import rce_pkg::*;
#(
   parameter int N_WIRES = 3,
   parameter int MAX_GATES = 16,
   localparam int DEPTH = 1 << N_WIRES,
   localparam int CODE_W = N_WIRES,
   localparam int ADDR_W = $clog2(MAX_GATES),
   localparam int CNT_W = $clog2(MAX_GATES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [1:0]           wr_op,
   input  logic [RCE_IDX_W-1:0] wr_tgt,
   input  logic [RCE_IDX_W-1:0] wr_aux_a,
   input  logic [RCE_IDX_W-1:0] wr_aux_b,
   input  logic [CNT_W-1:0]     gate_cnt,
   input  logic                 start,
   output logic                 busy,
   output logic                 done,
   output logic                 err,
   output logic                 is_perm,
   output logic                 is_odd,
   input  logic [CODE_W-1:0]    rd_addr,
   output logic [CODE_W-1:0]    rd_data
);
   localparam logic [CODE_W-1:0] LAST = CODE_W'(DEPTH - 1);

   initial begin
      assert (N_WIRES >= 2 && N_WIRES <= RCE_MAX_WIRES)
         else $fatal(1, "N_WIRES must lie in 2..%0d", RCE_MAX_WIRES);
      assert (MAX_GATES >= 2)
         else $fatal(1, "MAX_GATES must be at least 2");
   end

   typedef enum logic [1:0] {T_IDLE, T_RUN, T_WALK} tst_e;

   tst_e              st;
   logic [CODE_W-1:0] code, cur;
   logic [CNT_W-1:0]  gidx, cnt_q;
   logic [DEPTH-1:0]  seen;
   logic              dup;
   logic              walk_go;
   logic [CODE_W-1:0] tbl [DEPTH];

   rce_gate_t         wr_gate, cur_gate;
   logic [CODE_W-1:0] g_next;
   logic              g_illegal;
   logic [CODE_W-1:0] look_addr;
   logic              walk_fin, walk_odd;

   assign busy    = (st != T_IDLE);
   assign wr_gate = '{op: rce_op_e'(wr_op), tgt: wr_tgt, aux_a: wr_aux_a, aux_b: wr_aux_b};

   rce_gate_store #(.MAX_GATES(MAX_GATES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .lock_i    (busy),
      .wr_addr_i (wr_addr),
      .wr_gate_i (wr_gate),
      .rd_addr_i (gidx[ADDR_W-1:0]),
      .rd_gate_o (cur_gate)
   );

   rce_gate_apply #(.N_WIRES(N_WIRES)) u_apply (
      .state_i   (cur),
      .gate_i    (cur_gate),
      .state_o   (g_next),
      .illegal_o (g_illegal)
   );

   rce_parity_walk #(.N_WIRES(N_WIRES)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (walk_go),
      .look_addr_o (look_addr),
      .look_data_i (tbl[look_addr]),
      .fin_o       (walk_fin),
      .odd_o       (walk_odd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= T_IDLE;
         code    <= '0;
         cur     <= '0;
         gidx    <= '0;
         cnt_q   <= '0;
         seen    <= '0;
         dup     <= 1'b0;
         walk_go <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         is_perm <= 1'b0;
         is_odd  <= 1'b0;
         for (int k = 0; k < DEPTH; k++) tbl[k] <= '0;
      end else begin
         done    <= 1'b0;
         walk_go <= 1'b0;
         unique case (st)
            T_IDLE: if (start) begin
               cnt_q   <= gate_cnt;
               code    <= '0;
               cur     <= '0;
               gidx    <= '0;
               seen    <= '0;
               dup     <= 1'b0;
               err     <= 1'b0;
               is_perm <= 1'b0;
               is_odd  <= 1'b0;
               st      <= T_RUN;
            end
            T_RUN: begin
               if (gidx == cnt_q) begin
                  tbl[code]  <= cur;
                  seen[cur]  <= 1'b1;
                  if (seen[cur]) dup <= 1'b1;
                  if (code == LAST) begin
                     if (dup || seen[cur]) begin
                        done <= 1'b1;
                        st   <= T_IDLE;
                     end else begin
                        walk_go <= 1'b1;
                        st      <= T_WALK;
                     end
                  end else begin
                     code <= code + 1'b1;
                     cur  <= code + 1'b1;
                     gidx <= '0;
                  end
               end else if (g_illegal) begin
                  err  <= 1'b1;
                  done <= 1'b1;
                  st   <= T_IDLE;
               end else begin
                  cur  <= g_next;
                  gidx <= gidx + 1'b1;
               end
            end
            T_WALK: if (walk_fin) begin
               done    <= 1'b1;
               is_perm <= 1'b1;
               is_odd  <= walk_odd;
               st      <= T_IDLE;
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   assign rd_data = tbl[rd_addr];

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R7
   perm_on_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> is_perm);

   // R9
   err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (!is_perm && !is_odd));
endmodule

// File: tb/rev_cascade_eval_tb.sv
`timescale 1ns/1ps
module rev_cascade_eval_tb;
   localparam int NW = 3;
   localparam int MG = 16;
   localparam int DEP = 1 << NW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [1:0] wr_op = '0, wr_tgt = '0, wr_aux_a = '0, wr_aux_b = '0;
   logic [4:0] gate_cnt = '0;
   logic       start = 1'b0;
   logic       busy, done, err, is_perm, is_odd;
   logic [2:0] rd_addr = '0;
   logic [2:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rev_cascade_eval #(.N_WIRES(NW), .MAX_GATES(MG)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_op(wr_op),
      .wr_tgt(wr_tgt), .wr_aux_a(wr_aux_a), .wr_aux_b(wr_aux_b), .gate_cnt(gate_cnt),
      .start(start), .busy(busy), .done(done), .err(err), .is_perm(is_perm),
      .is_odd(is_odd), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [7:0] gt(input logic [1:0] op, t, a, b);
      return {op, t, a, b};
   endfunction

   typedef struct packed {
      logic [3:0]  cnt;
      logic [7:0]  g0, g1, g2;
      logic        odd;
      logic        bad;
      logic [23:0] tbl;
   } vec_t;

   localparam logic [23:0] ID = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};

   localparam vec_t VEC [12] = '{
      '{4'd0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, ID},
      '{4'd1, gt(1,0,1,0), 8'h0, 8'h0, 1'b0, 1'b0, {3'd6,3'd7,3'd5,3'd4,3'd2,3'd3,3'd1,3'd0}},
      '{4'd1, gt(2,0,1,2), 8'h0, 8'h0, 1'b1, 1'b0, {3'd6,3'd7,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}},
      '{4'd1, gt(0,2,0,0), 8'h0, 8'h0, 1'b0, 1'b0, {3'd3,3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4}},
      '{4'd1, gt(3,0,2,0), 8'h0, 8'h0, 1'b0, 1'b0, {3'd7,3'd3,3'd5,3'd1,3'd6,3'd2,3'd4,3'd0}},
      '{4'd2, gt(0,0,0,0), gt(1,1,0,0), 8'h0, 1'b0, 1'b0, {3'd6,3'd5,3'd4,3'd7,3'd2,3'd1,3'd0,3'd3}},
      '{4'd2, gt(1,1,0,0), gt(0,0,0,0), 8'h0, 1'b0, 1'b0, {3'd4,3'd7,3'd6,3'd5,3'd0,3'd3,3'd2,3'd1}},
      '{4'd2, gt(2,2,0,1), gt(2,1,2,0), 8'h0, 1'b0, 1'b0, {3'd3,3'd6,3'd7,3'd4,3'd5,3'd2,3'd1,3'd0}},
      '{4'd3, gt(1,0,1,0), gt(1,0,1,0), gt(3,1,2,0), 1'b0, 1'b0, {3'd7,3'd6,3'd3,3'd2,3'd5,3'd4,3'd1,3'd0}},
      '{4'd1, gt(1,1,1,0), 8'h0, 8'h0, 1'b0, 1'b1, ID},
      '{4'd2, gt(1,0,1,0), gt(0,3,0,0), 8'h0, 1'b0, 1'b1, ID},
      '{4'd1, gt(2,0,1,0), 8'h0, 8'h0, 1'b0, 1'b1, ID}
   };

   string VREQ [12] = '{"R5", "R2", "R3", "R1", "R4", "R5", "R5", "R3",
                        "R5", "R9", "R9", "R9"};

   task automatic chk(input string req, input string what, input logic [31:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_gate(input int addr, input logic [7:0] g);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(addr);
      {wr_op, wr_tgt, wr_aux_a, wr_aux_b} = g;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
      chk(req, "done seen", {31'd0, done}, 32'd1);
      @(negedge clk);
      // R11: single-cycle pulse
      chk("R11", "done fell", {31'd0, done}, 32'd0);
   endtask

   task automatic kick(input int cnt);
      @(negedge clk);
      start = 1'b1; gate_cnt = 5'(cnt);
      @(negedge clk);
      start = 1'b0;
      // R6: busy the cycle after start
      chk("R6", "busy after start", {31'd0, busy}, 32'd1);
   endtask

   task automatic rd(input string req, input int a, input logic [2:0] exp);
      rd_addr = 3'(a);
      #1;
      chk(req, $sformatf("image of %0d", a), {29'd0, rd_data}, {29'd0, exp});
   endtask

   initial begin
      #1200000;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 R11: reset state
      chk("R6", "reset busy", {31'd0, busy}, 32'd0);
      chk("R11", "reset done", {31'd0, done}, 32'd0);
      chk("R9", "reset err", {31'd0, err}, 32'd0);
      chk("R7", "reset is_perm", {31'd0, is_perm}, 32'd0);

      for (int v = 0; v < 12; v++) begin
         wr_gate(0, VEC[v].g0);
         wr_gate(1, VEC[v].g1);
         wr_gate(2, VEC[v].g2);
         kick(int'(VEC[v].cnt));
         wait_done(VREQ[v]);
         chk(VREQ[v], $sformatf("v%0d err", v), {31'd0, err}, {31'd0, VEC[v].bad});
         // R7 R8 R9
         chk(VEC[v].bad ? "R9" : "R7", $sformatf("v%0d is_perm", v),
             {31'd0, is_perm}, {31'd0, !VEC[v].bad});
         chk("R8", $sformatf("v%0d is_odd", v), {31'd0, is_odd}, {31'd0, VEC[v].odd});
         if (!VEC[v].bad) begin
            for (int a = 0; a < DEP; a++) rd(VREQ[v], a, VEC[v].tbl[3*a +: 3]);
         end
      end

      // R10: a write while busy is dropped
      wr_gate(0, gt(1,0,1,0));
      kick(1);
      wr_en = 1'b1; wr_addr = 4'd0;
      {wr_op, wr_tgt, wr_aux_a, wr_aux_b} = gt(0,2,0,0);
      @(negedge clk);
      wr_en = 1'b0;
      wait_done("R10");
      rd("R10", 2, 3'd3);
      kick(1);
      wait_done("R10");
      rd("R10", 0, 3'd0);
      rd("R10", 2, 3'd3);
      chk("R10", "parity after dropped write", {31'd0, is_odd}, 32'd0);

      // R10: write in the same cycle as start is used by that run
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd0;
      {wr_op, wr_tgt, wr_aux_a, wr_aux_b} = gt(2,0,1,2);
      start = 1'b1; gate_cnt = 5'd1;
      @(negedge clk);
      wr_en = 1'b0; start = 1'b0;
      wait_done("R10");
      rd("R10", 6, 3'd7);
      rd("R10", 2, 3'd2);
      chk("R10", "same-cycle parity", {31'd0, is_odd}, 32'd1);

      // R11: results hold while idle
      repeat (5) @(negedge clk);
      chk("R11", "is_odd held", {31'd0, is_odd}, 32'd1);
      chk("R11", "is_perm held", {31'd0, is_perm}, 32'd1);
      rd("R11", 7, 3'd6);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule